// File: doc/BRIEF.md
# Bidirectional Event Timer with Compare Flags

The block is a 16-bit counter driven by two external pins and read and written through a small register port. In edge mode one pin is treated as a count clock and the other as a direction level. Every change of the count pin, whether rising or falling, moves the count by one. The direction pin picks whether that step goes up or down. In quadrature mode the two pins are read as the phases of an incremental encoder. The count follows the Gray-code phase order, so it tracks both motion and direction.

Several compare registers watch the count. A channel raises a one-cycle flag only when a counting step lands the count on that channel's value. Putting the count there by a register load, a software clear or the event-driven clear input never raises a flag. Both pins pass through synchronizers and are sampled on the system clock. Software can load the count, clear it, choose the mode and program the compare values.

Top module: `updown_match_timer`

## Requirements
- R1: After reset the count, every compare register and the mode field read 0, and no match flag is raised.
- R2: In edge mode (mode value 1), each rising and each falling transition of `cnt_pin` moves the count by exactly one. The count goes up when `dir_pin` is 1 and down when it is 0. A change of `dir_pin` alone does not count.
- R3: In stopped mode (mode value 0), pin activity leaves the count unchanged.
- R4: In quadrature mode (mode value 2), with the phase written as {`cnt_pin`,`dir_pin`}, the order 00→10→11→01→00 adds one per transition.
- R5: In quadrature mode the reverse order 00→01→11→10→00 subtracts one per transition.
- R6: In quadrature mode a transition in which both pins change at once leaves the count unchanged.
- R7: The count wraps modulo 2^16 in both directions: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R8: A channel's `match_flag` bit is high for exactly one cycle, in the cycle the new count is visible, when a counting step moves the count onto that channel's compare value. The channels act independently.
- R9: Writing the count register (address 0) with a value equal to a compare value raises no match.
- R10: Clearing the count, either by a write to address 2 or by `evt_clear`, raises no match, even when a compare value is 0.
- R11: When a count write and `evt_clear` fall in the same cycle, the count ends as either 0 or the written value. Which one is not specified.
- R12: The register map is: address 0 is the count (read and load), address 1 is the mode in bits [1:0], address 2 clears the count on any write, and address 8+i is compare channel i. Programmed values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin | input | 1 | Count clock in edge mode, phase A in quadrature mode (asynchronous) |
| dir_pin | input | 1 | Direction level in edge mode, phase B in quadrature mode (asynchronous) |
| evt_clear | input | 1 | Synchronous event-driven clear of the count |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for writes and reads |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| match_flag | output | 2 | One-cycle match pulse per compare channel |

## Verification
Edge mode is driven with rising and falling transitions under both direction levels. This separates a design that counts both edges from one that counts only one edge, and it shows whether the direction is taken from the right pin. Quadrature mode is walked forward, backward and with simultaneous double changes. This tells a correct Gray-order decoder from one that counts every change or mixes up the two phases. Compare values are reached in three ways: by stepping, by loading, and by either kind of clear. Only the first may produce a flag, and wrap-around is crossed in both directions. Long random walks in both modes keep the count near the compare values, so flag counts are compared many times against a bench model.

// File: rtl/umt_pkg.sv
package umt_pkg;

    // Counting mode held in the control register (address 1, bits [1:0])
    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_EDGE = 2'd1,
        MODE_QUAD = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    // Step request from the pin decoder to the counter
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Last sampled pin phase {count pin, direction pin}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

endpackage

// File: rtl/umt_pin_sync.sv
module umt_pin_sync #(
    parameter int STAGES = 2,
    parameter int PINS   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins_i,
    output logic [PINS-1:0] pins_o
);

    localparam int LAST = STAGES - 1;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins_i[p]};
            end
        end

        assign pins_o[p] = chain_q[LAST];
    end

endmodule

// File: rtl/umt_step_decoder.sv
module umt_step_decoder
    import umt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  mode_e       mode_i,
    input  logic [1:0]  phase_i,   // {count pin, direction pin}, synchronized
    output step_e       step_o
);

    phase_e state_q;

    // State register: it remembers the previous phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_00;
        end else begin
            state_q <= phase_e'(phase_i);
        end
    end

    // Step output: depends on mode, the previous phase and the new phase.
    always_comb begin
        step_o = STEP_NONE;
        unique case (mode_i)
            MODE_EDGE: begin
                if (phase_i[1] != state_q[1]) begin
                    step_o = phase_i[0] ? STEP_UP : STEP_DOWN;
                end
            end
            MODE_QUAD: begin
                unique case (state_q)
                    PH_00: begin
                        if (phase_i == 2'b10)      step_o = STEP_UP;
                        else if (phase_i == 2'b01) step_o = STEP_DOWN;
                    end
                    PH_10: begin
                        if (phase_i == 2'b11)      step_o = STEP_UP;
                        else if (phase_i == 2'b00) step_o = STEP_DOWN;
                    end
                    PH_11: begin
                        if (phase_i == 2'b01)      step_o = STEP_UP;
                        else if (phase_i == 2'b10) step_o = STEP_DOWN;
                    end
                    PH_01: begin
                        if (phase_i == 2'b00)      step_o = STEP_UP;
                        else if (phase_i == 2'b11) step_o = STEP_DOWN;
                    end
                    default: step_o = STEP_NONE;
                endcase
            end
            default: step_o = STEP_NONE;
        endcase
    end

endmodule

// File: rtl/umt_counter.sv
module umt_counter
    import umt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  step_e        step_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o,
    output logic         stepped_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // A clear wins over a load, and a load wins over a step.
    always_comb begin
        cnt_next_o = cnt_q;
        stepped_o  = 1'b0;
        if (clr_i) begin
            cnt_next_o = '0;
        end else if (load_i) begin
            cnt_next_o = load_val_i;
        end else begin
            unique case (step_i)
                STEP_UP: begin
                    cnt_next_o = cnt_q + ONE;
                    stepped_o  = 1'b1;
                end
                STEP_DOWN: begin
                    cnt_next_o = cnt_q - ONE;
                    stepped_o  = 1'b1;
                end
                default: cnt_next_o = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next_o;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/umt_compare_bank.sv
module umt_compare_bank #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr_en_i,
    input  logic [W-1:0]        wr_val_i,
    input  logic                stepped_i,
    input  logic [W-1:0]        cnt_next_i,
    output logic [N-1:0][W-1:0] cmp_o,
    output logic [N-1:0]        match_o
);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [W-1:0] cmp_q;
        logic         hit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_q <= '0;
            end else if (wr_en_i[i]) begin
                cmp_q <= wr_val_i;
            end
        end

        // The flag is registered with the count, so both show in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit_q <= 1'b0;
            end else begin
                hit_q <= stepped_i && (cnt_next_i == cmp_q);
            end
        end

        assign cmp_o[i]   = cmp_q;
        assign match_o[i] = hit_q;
    end

endmodule

// File: rtl/updown_match_timer.sv
module updown_match_timer
    import umt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_CMP     = 2,   // 1..8 channels at addresses 8..15
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_pin,
    input  logic               dir_pin,
    input  logic               evt_clear,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [NUM_CMP-1:0] match_flag
);

    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(2);
    localparam int                CMP_BASE = 8;

    logic [1:0]                    phase_s;
    step_e                         step;
    mode_e                         mode_q;
    logic [CNT_W-1:0]              cnt_q;
    logic [CNT_W-1:0]              cnt_next;
    logic                          stepped;
    logic [NUM_CMP-1:0]            cmp_wr;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
    logic                          do_clr;
    logic                          do_load;

    umt_pin_sync #(.STAGES(SYNC_STAGES), .PINS(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({cnt_pin, dir_pin}),
        .pins_o (phase_s)
    );

    umt_step_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_q),
        .phase_i (phase_s),
        .step_o  (step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_STOP;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            mode_q <= mode_e'(bus_wdata[1:0]);
        end
    end

    assign do_clr  = evt_clear || (bus_wr && bus_addr == A_CLEAR);
    assign do_load = bus_wr && bus_addr == A_COUNT;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_wr
        assign cmp_wr[i] = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + i));
    end

    umt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (do_clr),
        .load_i     (do_load),
        .load_val_i (bus_wdata),
        .step_i     (step),
        .cnt_o      (cnt_q),
        .cnt_next_o (cnt_next),
        .stepped_o  (stepped)
    );

    umt_compare_bank #(.W(CNT_W), .N(NUM_CMP)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cmp_wr),
        .wr_val_i   (bus_wdata),
        .stepped_i  (stepped),
        .cnt_next_i (cnt_next),
        .cmp_o      (cmp_val),
        .match_o    (match_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_COUNT) begin
            bus_rdata = cnt_q;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata = CNT_W'(mode_q);
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_addr == ADDR_W'(CMP_BASE + i)) bus_rdata = cmp_val[i];
        end
    end

endmodule

// File: rtl/umt_checker.sv
module umt_checker #(
    parameter int W  = 16,
    parameter int N  = 2,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          evt_clear,
    input logic [1:0]    mode,
    input logic [W-1:0]  cnt,
    input logic [N-1:0]  match
);

    assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !evt_clear) |=>
            (cnt == $past(cnt) || cnt == W'($past(cnt) + W'(1)) || cnt == W'($past(cnt) - W'(1))));

    assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !bus_wr && !evt_clear) |=> $stable(cnt));

    assert_match_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |-> (cnt != $past(cnt)));

    assert_no_match_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(0)) |=> (match == '0));

    assert_no_match_evclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clear |=> (match == '0));

    assert_no_match_swclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(2)) |=> (match == '0));

endmodule

bind updown_match_timer umt_checker #(.W(CNT_W), .N(NUM_CMP), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .evt_clear (evt_clear),
    .mode      (mode_q),
    .cnt       (cnt_q),
    .match     (match_flag)
);

// File: tb/sim_updown_match_timer.sv
module sim_updown_match_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_pin = 1'b0;
    logic          dir_pin = 1'b0;
    logic          evt_clear = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [NC-1:0] match_flag;

    int n_checks = 0;
    int n_err = 0;
    logic [15:0] exp_cnt = '0;
    logic [15:0] exp_cmp [NC];
    int exp_match [NC];
    int seen_match [NC];
    logic [1:0] exp_mode = 2'd0;

    updown_match_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_pin    (cnt_pin),
        .dir_pin    (dir_pin),
        .evt_clear  (evt_clear),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .match_flag (match_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NC; i++) if (match_flag[i]) seen_match[i]++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 4'd0) exp_cnt = d;
        if (a == 4'd1) exp_mode = d[1:0];
        if (a == 4'd2) exp_cnt = '0;
        for (int i = 0; i < NC; i++) if (a == 4'(8 + i)) exp_cmp[i] = d;
    endtask

    task automatic model_step(input bit up);
        exp_cnt = up ? exp_cnt + 16'd1 : exp_cnt - 16'd1;
        for (int i = 0; i < NC; i++) if (exp_cnt == exp_cmp[i]) exp_match[i]++;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic edge_step(input bit up);
        @(negedge clk);
        dir_pin = up;
        settle();
        cnt_pin = ~cnt_pin;
        settle();
        if (exp_mode == 2'd1) model_step(up);
    endtask

    function automatic logic [1:0] quad_next(input logic [1:0] p, input bit up);
        case (p)
            2'b00: return up ? 2'b10 : 2'b01;
            2'b10: return up ? 2'b11 : 2'b00;
            2'b11: return up ? 2'b01 : 2'b10;
            default: return up ? 2'b00 : 2'b11;
        endcase
    endfunction

    task automatic quad_step(input bit up);
        logic [1:0] n;
        n = quad_next({cnt_pin, dir_pin}, up);
        @(negedge clk);
        {cnt_pin, dir_pin} = n;
        settle();
        model_step(up);
    endtask

    task automatic quad_double();
        @(negedge clk);
        {cnt_pin, dir_pin} = ~{cnt_pin, dir_pin};
        settle();
    endtask

    task automatic pulse_evclr();
        @(negedge clk);
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
        exp_cnt = '0;
    endtask

    task automatic check_cnt(input string req);
        logic [15:0] v;
        rd(4'd0, v);
        check(req, {16'd0, v}, {16'd0, exp_cnt});
    endtask

    task automatic check_matches(input string req);
        @(negedge clk);
        for (int i = 0; i < NC; i++) check(req, seen_match[i], exp_match[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] r1;
        logic [15:0] r2;
        void'($urandom(32'd4711));
        for (int i = 0; i < NC; i++) begin
            exp_cmp[i] = '0;
            exp_match[i] = 0;
            seen_match[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v); check("R1 count", {16'd0, v}, 32'd0);
        rd(4'd1, v); check("R1 mode", {16'd0, v}, 32'd0);
        rd(4'd8, v); check("R1 cmp0", {16'd0, v}, 32'd0);
        rd(4'd9, v); check("R1 cmp1", {16'd0, v}, 32'd0);
        check("R1 no match", {30'd0, match_flag}, 32'd0);

        // R12 register readback
        wr(4'd8, 16'h1234); rd(4'd8, v); check("R12 cmp0", {16'd0, v}, 32'h1234);
        wr(4'd9, 16'hBEEF); rd(4'd9, v); check("R12 cmp1", {16'd0, v}, 32'hBEEF);
        wr(4'd1, 16'd2);    rd(4'd1, v); check("R12 mode", {16'd0, v}, 32'd2);

        // R3 stopped mode ignores pins
        wr(4'd1, 16'd0);
        wr(4'd0, 16'h0010);
        for (int k = 0; k < 4; k++) edge_step(k[0]);
        check_cnt("R3 stop");

        // R2 both edges, direction control
        wr(4'd1, 16'd1);
        edge_step(1'b1); edge_step(1'b1); edge_step(1'b1);
        check("R2 up three edges", {16'd0, exp_cnt}, 32'h13);
        check_cnt("R2 up");
        edge_step(1'b0); edge_step(1'b0);
        check_cnt("R2 down");
        @(negedge clk); dir_pin = ~dir_pin; settle();
        check_cnt("R2 dir alone");

        // R8 step onto compare, R9 load onto compare
        wr(4'd8, 16'h0014);
        wr(4'd9, 16'h0012);
        edge_step(1'b1); edge_step(1'b1); edge_step(1'b1);
        check_matches("R8 step match");
        check("R8 ch0 once", seen_match[0], 1);
        wr(4'd0, 16'h0014);
        wr(4'd0, 16'h0012);
        check_matches("R9 load no match");
        check_cnt("R9 load value");

        // R10 clears with compare at zero
        wr(4'd8, 16'h0000);
        wr(4'd0, 16'h0005);
        wr(4'd2, 16'h0000);
        check_cnt("R10 sw clear");
        wr(4'd0, 16'h0007);
        pulse_evclr();
        check_cnt("R10 event clear");
        check_matches("R10 no match");
        wr(4'd0, 16'h0001);
        edge_step(1'b0);
        check_matches("R10 step to zero matches");

        // R7 wrap both ways
        wr(4'd0, 16'hFFFF);
        edge_step(1'b1);
        check_cnt("R7 wrap up");
        edge_step(1'b0);
        check_cnt("R7 wrap down");
        check_matches("R7 matches");

        // R4 R5 R6 quadrature directed
        wr(4'd1, 16'd2);
        wr(4'd0, 16'h0100);
        for (int k = 0; k < 4; k++) quad_step(1'b1);
        check_cnt("R4 quad up");
        for (int k = 0; k < 6; k++) quad_step(1'b0);
        check_cnt("R5 quad down");
        quad_double();
        check_cnt("R6 double change");

        // Random edge walk near compare values (R2 R8)
        wr(4'd1, 16'd1);
        wr(4'd8, exp_cnt + 16'd3);
        wr(4'd9, exp_cnt - 16'd2);
        for (int k = 0; k < 150; k++) begin
            edge_step(1'($urandom_range(0, 1)));
            if (k % 10 == 9) check_cnt("R2 random edge");
        end
        check_matches("R8 random edge");

        // Random quadrature walk with double changes (R4 R5 R6 R8)
        wr(4'd1, 16'd2);
        for (int k = 0; k < 150; k++) begin
            if ($urandom_range(0, 9) == 0) quad_double();
            else quad_step(1'($urandom_range(0, 1)));
            if (k % 10 == 9) check_cnt("R4 R5 random quad");
        end
        check_matches("R8 random quad");

        // R11 write coinciding with event clear: outcome only checked for consistency
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 16'h5A5A; evt_clear = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0; evt_clear = 1'b0;
            rd(4'd0, v);
            if (k == 0) r1 = v; else r2 = v;
        end
        check("R11 legal outcome", {31'd0, (r1 == 16'h0000 || r1 == 16'h5A5A)}, 32'd1);
        check("R11 deterministic", {16'd0, r2}, {16'd0, r1});
        check_matches("R11 no match");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule